// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This unit carries out the four partial-word memory operations that let software reach a 32-bit word sitting at any byte address: a left load, a right load, a left store and a right store. Byte lanes are numbered big-endian style. Offset 0 names the most significant byte of the aligned word. The two low bits of the effective address pick the offset. The memory itself is only ever addressed on a word boundary.

A load reads the aligned word once and merges some of its bytes into the current value of the destination register. It then returns the merged word with a write enable. A store reads the aligned word, replaces only the bytes the offset selects with bytes from the register value, and writes the word back. That is a read-modify-write over a simple request/valid memory port. One operation is accepted at a time. A single-cycle `done` pulse closes each one.

Top module: `unaligned_merge_unit`

## Requirements
- R1: Every memory request uses the start address with its two low bits forced to zero. The two low bits of the start address (the offset) select the shift and the mask.
- R2: Left load (op code 0), offset k: the result is the memory word shifted left by 8*(3-k) bits. It is ORed with the register bits that lie below that shifted field, so offsets 0..3 keep the low 3, 2, 1 and 0 register bytes.
- R3: Right load (op code 1), offset k: the result is the memory word shifted right by 8*k bits. It is ORed with the register bits above that field, so offsets 0..3 keep the top 0, 1, 2 and 3 register bytes.
- R4: Left store (op code 2), offset k: the written word is the register shifted right by 8*(3-k) bits. Memory bytes above that field are kept, so offsets 0..3 keep the top 3, 2, 1 and 0 memory bytes.
- R5: Right store (op code 3), offset k: the written word is the register shifted left by 8*k bits. Memory bytes below that field are kept, so offsets 0..3 keep the low 0, 1, 2 and 3 memory bytes.
- R6: A load whose destination index is 0 still issues its memory read and still pulses `done`, but `res_we` stays low.
- R7: A store issues one read, waits any number of cycles for `mem_rvalid`, and then issues exactly one write in the cycle after the data arrives. It never raises `res_we`. A load never writes memory.
- R8: `done` is high for exactly one cycle per operation. For a load to a nonzero index, `res_we` is high in that same cycle, with `res_idx` equal to the index given at start and `res_data` holding the merged word.
- R9: A `start` raised while the unit is busy is ignored. The running operation finishes with its own values, and no second operation follows.
- R10: After reset the unit is idle, with `busy`, `mem_req`, `done` and `res_we` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 left load, 1 right load, 2 left store, 3 right store |
| addr | input | 32 | Effective byte address |
| reg_val | input | 32 | Current destination register value (load) or source value (store) |
| dest_idx | input | 5 | Destination register index for loads |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Merged word for the write |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_we | output | 1 | Register write enable for loads |
| res_idx | output | 5 | Register index of the result |
| res_data | output | 32 | Merged load result |

## Verification
The assertions take for granted that `mem_rvalid` comes exactly once for each read request, and only after that request's cycle. A write is therefore always preceded by valid data, and the address seen in the read cycle relates to the address at the accepting `start`. The bench's memory model answers each read once, after a chosen latency of one or more cycles, and never raises `mem_rvalid` on its own. The bench holds `start` high for a single cycle, except in the deliberate busy-time `start` of the ignore test.

// File: rtl/uam_pkg.sv
package uam_pkg;

  typedef enum logic [1:0] {
    OP_LD_LEFT  = 2'd0,
    OP_LD_RIGHT = 2'd1,
    OP_ST_LEFT  = 2'd2,
    OP_ST_RIGHT = 2'd3
  } uam_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } uam_state_e;

  function automatic logic op_is_store(uam_op_e o);
    return o[1];
  endfunction

  function automatic logic op_is_right(uam_op_e o);
    return o[0];
  endfunction

endpackage

// File: rtl/uam_ctrl.sv
module uam_ctrl
  import uam_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_store,
  input  logic rvalid,
  output logic in_idle,
  output logic in_read,
  output logic in_wait,
  output logic in_write,
  output logic in_done,
  output logic ev_accept,
  output logic ev_rdata
);

  uam_state_e state_q, state_d;

  assign in_idle  = (state_q == ST_IDLE);
  assign in_read  = (state_q == ST_READ);
  assign in_wait  = (state_q == ST_WAIT);
  assign in_write = (state_q == ST_WRITE);
  assign in_done  = (state_q == ST_DONE);

  assign ev_accept = in_idle && start;
  assign ev_rdata  = in_wait && rvalid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_WAIT;
      ST_WAIT:  if (rvalid) state_d = is_store ? ST_WRITE : ST_DONE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({in_idle, in_read, in_wait, in_write, in_done})); // R7
  AST_WRITE_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    in_write |-> $past(rvalid)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |=> in_idle); // R8

endmodule

// File: rtl/uam_load_merge.sv
module uam_load_merge #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              right,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] reg_word,
  output logic [DATA_W-1:0] merged
);

  function automatic logic [DATA_W-1:0] ld_merge(
    input logic              r,
    input logic [OFF_W-1:0]  k,
    input logic [DATA_W-1:0] m,
    input logic [DATA_W-1:0] g
  );
    logic [DATA_W-1:0] ones;
    int unsigned sh;
    ones = '1;
    if (!r) begin
      sh = 8 * (LANES - 1 - int'(k));
      return (m << sh) | (g & ~(ones << sh));
    end
    sh = 8 * int'(k);
    return (m >> sh) | (g & ~(ones >> sh));
  endfunction

  assign merged = ld_merge(right, off, mem_word, reg_word);

endmodule

// File: rtl/uam_store_merge.sv
module uam_store_merge #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              right,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] reg_word,
  output logic [DATA_W-1:0] merged
);

  function automatic logic [DATA_W-1:0] st_merge(
    input logic              r,
    input logic [OFF_W-1:0]  k,
    input logic [DATA_W-1:0] m,
    input logic [DATA_W-1:0] g
  );
    logic [DATA_W-1:0] ones;
    int unsigned sh;
    ones = '1;
    if (!r) begin
      sh = 8 * (LANES - 1 - int'(k));
      return (g >> sh) | (m & ~(ones >> sh));
    end
    sh = 8 * int'(k);
    return (g << sh) | (m & ~(ones << sh));
  endfunction

  assign merged = st_merge(right, off, mem_word, reg_word);

endmodule

// File: rtl/unaligned_merge_unit.sv
module unaligned_merge_unit
  import uam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IDX_W-1:0]  dest_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              busy,
  output logic              done,
  output logic              res_we,
  output logic [IDX_W-1:0]  res_idx,
  output logic [DATA_W-1:0] res_data
);

  uam_op_e                  op_q;
  logic [OFF_W-1:0]         off_q;
  logic [ADDR_W-OFF_W-1:0]  word_q;
  logic [DATA_W-1:0]        reg_q;
  logic [DATA_W-1:0]        rdata_q;
  logic [IDX_W-1:0]         idx_q;

  logic in_idle, in_read, in_wait, in_write, in_done;
  logic ev_accept, ev_rdata;
  logic store_q;

  assign store_q = op_is_store(op_q);

  uam_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_store  (store_q),
    .rvalid    (mem_rvalid),
    .in_idle   (in_idle),
    .in_read   (in_read),
    .in_wait   (in_wait),
    .in_write  (in_write),
    .in_done   (in_done),
    .ev_accept (ev_accept),
    .ev_rdata  (ev_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= OP_LD_LEFT;
      off_q   <= '0;
      word_q  <= '0;
      reg_q   <= '0;
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (ev_accept) begin
        op_q   <= uam_op_e'(op);
        off_q  <= addr[OFF_W-1:0];
        word_q <= addr[ADDR_W-1:OFF_W];
        reg_q  <= reg_val;
        idx_q  <= dest_idx;
      end
      if (ev_rdata) rdata_q <= mem_rdata;
    end
  end

  logic [DATA_W-1:0] ld_word, st_word;

  uam_load_merge #(.DATA_W(DATA_W)) u_ld (
    .right    (op_is_right(op_q)),
    .off      (off_q),
    .mem_word (rdata_q),
    .reg_word (reg_q),
    .merged   (ld_word)
  );

  uam_store_merge #(.DATA_W(DATA_W)) u_st (
    .right    (op_is_right(op_q)),
    .off      (off_q),
    .mem_word (rdata_q),
    .reg_word (reg_q),
    .merged   (st_word)
  );

  assign mem_req   = in_read || in_write;
  assign mem_we    = in_write;
  assign mem_addr  = {word_q, {OFF_W{1'b0}}};
  assign mem_wdata = st_word;
  assign busy      = !in_idle;
  assign done      = in_done;
  assign res_we    = in_done && !store_q && (idx_q != '0);
  assign res_idx   = idx_q;
  assign res_data  = ld_word;

  AST_ALIGNED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |-> mem_addr == {$past(addr[ADDR_W-1:OFF_W]), {OFF_W{1'b0}}}); // R1
  AST_SAME_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $stable(mem_addr)); // R1
  AST_LOAD_NO_MEM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> store_q); // R7
  AST_IDX_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_idx != '0); // R6
  AST_RESULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q)); // R9

endmodule

// File: tb/unaligned_merge_unit_test.sv
`timescale 1ns/1ps
module unaligned_merge_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] addr = '0;
  logic [31:0] reg_val = '0;
  logic [4:0]  dest_idx = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic        busy, done, res_we;
  logic [4:0]  res_idx;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  unaligned_merge_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .reg_val(reg_val), .dest_idx(dest_idx), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .busy(busy), .done(done), .res_we(res_we),
    .res_idx(res_idx), .res_data(res_data)
  );

  // memory model: 16 words, answers each read once after mem_lat cycles
  logic [31:0] mem_arr [16];
  int mem_lat = 1;
  int cnt = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [3:0]  raddr = '0;
  logic [31:0] last_addr = '0;

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_arr[raddr];
      end
    end
    if (rst_n && mem_req && !mem_we) begin
      cnt = mem_lat;
      raddr = mem_addr[5:2];
      last_addr = mem_addr;
      rd_cnt++;
    end
    if (rst_n && mem_req && mem_we) begin
      mem_arr[mem_addr[5:2]] = mem_wdata;
      last_addr = mem_addr;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // lane-by-lane reference (lane 0 = least significant byte)
  function automatic logic [31:0] ref_result(input logic [1:0] o, input int k,
                                             input logic [31:0] m, input logic [31:0] g);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      case (o)
        2'd0: r[8*i +: 8] = (i >= 3 - k) ? m[8*(i-(3-k)) +: 8] : g[8*i +: 8];
        2'd1: r[8*i +: 8] = (i + k <= 3) ? m[8*(i+k) +: 8] : g[8*i +: 8];
        2'd2: r[8*i +: 8] = (i <= k) ? g[8*(i+3-k) +: 8] : m[8*i +: 8];
        default: r[8*i +: 8] = (i >= k) ? g[8*(i-k) +: 8] : m[8*i +: 8];
      endcase
    end
    return r;
  endfunction

  function automatic string op_req(input logic [1:0] o);
    case (o)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] rv,
                        input logic [4:0] idx, input int lat, input bit inject,
                        input logic [31:0] mword);
    int rd0, wr0, cyc;
    logic [31:0] expv;
    string rq;
    rq = op_req(o);
    mem_arr[a[5:2]] = mword;
    mem_lat = lat;
    rd0 = rd_cnt; wr0 = wr_cnt;
    expv = ref_result(o, int'(a[1:0]), mword, rv);
    @(negedge clk);
    start = 1'b1; op = o; addr = a; reg_val = rv; dest_idx = idx;
    @(negedge clk);
    start = 1'b0; op = ~o; addr = ~a; reg_val = ~rv; dest_idx = ~idx;
    cyc = 0;
    while (!done && cyc < 60) begin
      start = (inject && cyc == 1);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R8", "done seen", 32'(done), 32'd1);
    chk(rd_cnt - rd0 == 1, "R7", "reads issued", 32'(rd_cnt - rd0), 32'd1);
    chk(last_addr == {a[31:2], 2'b00}, "R1", "aligned address", last_addr, {a[31:2], 2'b00});
    if (o[1]) begin
      chk(wr_cnt - wr0 == 1, "R7", "store writes", 32'(wr_cnt - wr0), 32'd1);
      chk(res_we == 1'b0, "R7", "store res_we", 32'(res_we), 32'd0);
      chk(mem_arr[a[5:2]] == expv, rq, "stored word", mem_arr[a[5:2]], expv);
    end else begin
      chk(wr_cnt == wr0, "R7", "load writes", 32'(wr_cnt - wr0), 32'd0);
      if (idx == 5'd0) begin
        chk(res_we == 1'b0, "R6", "index 0 res_we", 32'(res_we), 32'd0);
      end else begin
        chk(res_we == 1'b1, "R8", "res_we with done", 32'(res_we), 32'd1);
        chk(res_idx == idx, "R8", "res_idx", 32'(res_idx), 32'(idx));
        chk(res_data == expv, rq, "load result", res_data, expv);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", 32'(done), 32'd0);
    chk(busy == 1'b0 && mem_req == 1'b0, inject ? "R9" : "R8", "idle after done",
        32'({busy, mem_req}), 32'd0);
  endtask

  task automatic test_reset();
    chk(busy == 1'b0, "R10", "busy after reset", 32'(busy), 32'd0);
    chk(mem_req == 1'b0, "R10", "mem_req after reset", 32'(mem_req), 32'd0);
    chk(done == 1'b0 && res_we == 1'b0, "R10", "done/res_we after reset",
        32'({done, res_we}), 32'd0);
  endtask

  task automatic test_all_merges();
    for (int o = 0; o < 4; o++)
      for (int k = 0; k < 4; k++)
        run_op(2'(o), 32'h0000_0010 + 32'(k) + 32'(o * 4), 32'h5566_7788, 5'd9,
               1 + k, 1'b0, 32'hA1B2_C3D4);
  endtask

  task automatic test_index_zero();
    run_op(2'd0, 32'h0000_0021, 32'h1234_5678, 5'd0, 2, 1'b0, 32'hCAFE_BABE); // R6
    run_op(2'd1, 32'h0000_0032, 32'h1234_5678, 5'd0, 1, 1'b0, 32'hCAFE_BABE); // R6
  endtask

  task automatic test_busy_start();
    run_op(2'd1, 32'h0000_0027, 32'hDEAD_BEEF, 5'd4, 3, 1'b1, 32'h0102_0304); // R9
    run_op(2'd2, 32'h0000_0029, 32'hDEAD_BEEF, 5'd4, 3, 1'b1, 32'h0102_0304); // R9
  endtask

  task automatic test_long_latency();
    run_op(2'd3, 32'h0000_003D, 32'h8899_AABB, 5'd1, 7, 1'b0, 32'h1357_9BDF); // R7 R5
    run_op(2'd0, 32'h0000_0006, 32'hFFFF_FFFF, 5'd31, 5, 1'b0, 32'h0000_0000); // R2
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem_arr[i] = 32'h0;
    repeat (3) @(negedge clk);
    test_reset(); // R10
    rst_n = 1'b1;
    @(negedge clk);
    test_all_merges();
    test_index_zero();
    test_busy_start();
    test_long_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule